// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus. It frees the bus after a transfer was cut short, after a power loss or after a reset, when a slave may still be holding the data line low partway through a byte. A single-cycle request starts the recovery.

The sequencer first looks at the data line with the clock released. While the data line reads low, it issues clock pulses and samples the data line at the end of each high phase. It stops clocking as soon as the line reads high, and it never issues more than nine pulses.

With the data line free, it drives a start condition and then a stop condition, and reports completion. If the line is still low after the ninth pulse, it releases both lines and reports a failure.

Both lines are driven as open-drain pull-down enables. The block reads back the real line levels. Each clock phase lasts a parameterised number of system clocks, and a high phase counts only while the clock line actually reads high.

Top module: `bus_recover`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `busy_o`, `done_o` and `fail_o` are all 0. Whenever `busy_o` is 0, both pull-down enables are 0.
- R2: A `req_i` sampled high while idle starts the sequence, and `busy_o` is 1 from the next cycle. A `req_i` raised while busy has no effect on the pulse count, the timing or the number of completions.
- R3: The sequence opens with one high phase, with SCL released, at whose end SDA is sampled. If SDA reads high there, no clock pulse is issued and the sequence goes straight to the start condition.
- R4: Each recovery pulse holds SCL low (`scl_oe_o`=1) for HALF cycles and then releases it for a high phase of HALF cycles. SDA is sampled at the end of every high phase, and clocking stops at the first high sample.
- R5: At most nine recovery pulses are issued. If SDA still reads low at the end of the ninth high phase, `done_o` and `fail_o` pulse together and no start or stop condition is driven.
- R6: After a high sample, a start condition is driven: `sda_oe_o` rises while `scl_oe_o` is 0. SCL is then pulled low for one phase and released, and a stop condition is driven: `sda_oe_o` falls while `scl_oe_o` is 0. `done_o` then pulses with `fail_o` at 0.
- R7: Any phase with SCL released advances its timer only on cycles where `scl_i` reads high, so a slave stretching the clock lengthens the sequence by exactly the stretched cycles.
- R8: `done_o` is a one-cycle pulse, and `busy_o` is 0 in that same cycle. With p recovery pulses, `busy_o` is high for HALF*(5+2p) cycles on success and HALF*19 cycles on failure, plus any stretched cycles.
- R9: `sda_oe_o` stays 0 during the opening check and all recovery pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Recovery request, sampled while idle |
| scl_i | input | 1 | Actual SCL line level |
| sda_i | input | 1 | Actual SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | SDA still held low, valid with done_o |

## Verification
A wrong phase state shows at once as a misplaced edge on one of the two enables. An SDA transition while SCL is enabled low, or a missing start or stop, appears within one half-period. A wrong pulse count or a mishandled sample changes the number of SCL low phases and the busy length, and both are visible when the completion pulse arrives. Timer or stretch faults shift the busy length by whole cycles, so every sequence is checked for its exact duration.

// File: rtl/bus_recover.sv
module bus_recover #(
  parameter int HALF       = 4,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int CW = $clog2(HALF + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_LOW, S_HIGH, S_STA, S_SCLLO, S_SCLHI, S_STO
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [PW-1:0] npul;
  logic          run, tick;

  assign scl_oe_o = (state == S_LOW) || (state == S_SCLLO);
  assign sda_oe_o = (state == S_STA) || (state == S_SCLLO) || (state == S_SCLHI);
  assign busy_o   = (state != S_IDLE);
  assign run      = scl_oe_o || scl_i;
  assign tick     = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      npul   <= '0;
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      if (state == S_IDLE) begin
        cnt <= '0;
        if (req_i) begin
          state <= S_CHECK;
          npul  <= '0;
        end
      end else if (tick) begin
        cnt <= '0;
        case (state)
          S_CHECK: state <= sda_i ? S_STA : S_LOW;
          S_LOW:   state <= S_HIGH;
          S_HIGH: begin
            npul <= npul + 1'b1;
            if (sda_i) state <= S_STA;
            else if (npul == PW'(MAX_PULSES - 1)) begin
              state  <= S_IDLE;
              done_o <= 1'b1;
              fail_o <= 1'b1;
            end else state <= S_LOW;
          end
          S_STA:   state <= S_SCLLO;
          S_SCLLO: state <= S_SCLHI;
          S_SCLHI: state <= S_STO;
          S_STO: begin
            state  <= S_IDLE;
            done_o <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  lines_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));
  // R5
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npul <= PW'(MAX_PULSES));
  // R5
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o);
  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  start_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_oe_o);
  // R6
  stop_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o);
  // R9
  sda_free_clocking_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK || state == S_LOW || state == S_HIGH) |-> !sda_oe_o);
  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !scl_oe_o && !scl_i && $stable(state)) |=> $stable(cnt));
endmodule

// File: tb/bus_recover_tb.sv
module bus_recover_tb_top;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic stretch = 1'b0;
  int   rel_k = 0;
  int   base = 0;
  int   rel_total = 0;
  int   checks = 0;
  int   fails = 0;
  logic scl_oe, sda_oe, busy, done, fail;
  logic hold, scl_line, sda_line;

  always #4 clk = ~clk;

  assign hold     = (rel_total - base) < rel_k;
  assign scl_line = !scl_oe && !stretch;
  assign sda_line = !sda_oe && !hold;

  always @(negedge scl_oe) rel_total = rel_total + 1;

  bus_recover #(.HALF(H), .MAX_PULSES(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  typedef struct {
    int lows; int fl; int cycles; int starts; int stops; string tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  int   m_cyc = 0, m_lows = 0, m_sta = 0, m_sto = 0;
  logic p_scl = 1'b0, p_sda = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) m_cyc++;
      if (scl_oe && !p_scl) m_lows++;
      if (sda_oe && !p_sda) begin
        if (!scl_oe) m_sta++; else chk(0, "R6", "start with SCL low", 1, 0);
      end
      if (!sda_oe && p_sda) begin
        if (!scl_oe) m_sto++; else chk(0, "R6", "stop with SCL low", 1, 0);
      end
      if (done) begin
        if (q.size() == 0) chk(0, "R2", "unexpected completion", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(m_lows == e.lows, "R4", {e.tag, " SCL low phases"}, m_lows, e.lows);
          chk(int'(fail) == e.fl, "R5", {e.tag, " fail flag"}, int'(fail), e.fl);
          chk(m_cyc == e.cycles, "R8", {e.tag, " busy cycles"}, m_cyc, e.cycles);
          chk(m_sta == e.starts, "R6", {e.tag, " start count"}, m_sta, e.starts);
          chk(m_sto == e.stops, "R6", {e.tag, " stop count"}, m_sto, e.stops);
          chk(!busy, "R8", {e.tag, " busy low with done"}, int'(busy), 0);
        end
        m_cyc = 0; m_lows = 0; m_sta = 0; m_sto = 0;
      end
    end
    p_scl = scl_oe;
    p_sda = sda_oe;
  end

  task automatic run(input int k, input int st, input bit extra, input string tag);
    exp_t e;
    int p;
    p = (k > 9) ? 9 : k;
    e.fl     = (k > 9) ? 1 : 0;
    e.lows   = e.fl ? 9 : p + 1;
    e.cycles = (e.fl ? H * 19 : H * (5 + 2 * p)) + st;
    e.starts = e.fl ? 0 : 1;
    e.stops  = e.starts;
    e.tag    = tag;
    q.push_back(e);
    base  = rel_total;
    rel_k = k;
    @(negedge clk);
    if (st > 0) stretch = 1'b1;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy, "R2", {tag, " busy after request"}, int'(busy), 1);
    repeat (st) @(negedge clk);
    stretch = 1'b0;
    if (extra) begin
      repeat (12) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, "R8", {tag, " done one cycle"}, int'(done), 0);
    chk(!scl_oe && !sda_oe, "R1", {tag, " lines released after"}, int'(scl_oe) + int'(sda_oe), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !fail, "R1", "reset outputs",
        int'(scl_oe) + int'(sda_oe) + int'(busy) + int'(done) + int'(fail), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 0, 1'b0, "R3 line already free");
    run(1, 0, 1'b0, "R4 one pulse");
    run(4, 0, 1'b0, "R4 four pulses");
    run(9, 0, 1'b0, "R5 release on ninth");
    run(10, 0, 1'b0, "R5 never released");
    run(3, 0, 1'b1, "R2 request while busy");
    run(0, 7, 1'b0, "R7 clock stretched");
    run(2, 0, 1'b0, "R9 two pulses");
    chk(q.size() == 0, "R2", "all completions seen", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule